// File: doc/BRIEF.md
# Bit-Interleaving Lane Transposer

This block spreads a group of bytes across several parallel serial lanes one bit at a time, or gathers them back. Each of `LANES` flash devices sits on its own serial bus. In the stripe direction, consecutive bits of the logical stream are dealt round-robin to the lanes, so each lane receives one byte per group. In the destripe direction, the lane bytes that came back are reassembled into the logical order. A per-beat direction input picks one of the two mappings. The two mappings are exact inverses of each other.

Data enters on a valid/ready handshake as a vector of `LANES` bytes. It leaves one cycle later from an output register, on a second valid/ready handshake. The serial shifting and the FIFOs around the block are not part of it.

A two-state controller owns the output register:
- `ST_EMPTY` means the register holds nothing.
- `ST_FULL` means it holds a beat.

The controller has four named transitions:
- LOAD (`ST_EMPTY` to `ST_FULL`) happens on an accepted beat.
- STREAM (`ST_FULL` to `ST_FULL`) drains the held beat and accepts a new one in the same cycle.
- STALL (`ST_FULL` to `ST_FULL`) holds the beat while the output is not ready.
- DRAIN (`ST_FULL` to `ST_EMPTY`) drains the held beat with no new input.

Top module: `bit_stripe_xpose`

## Requirements
- R1: With `dir_i`=0 (stripe), let j = 8*b + i be the flat index of output byte b, bit i. That output bit equals input byte (j mod LANES), bit (j div LANES). Byte k occupies bits [8k+7:8k] of each data vector.
- R2: With `dir_i`=1 (destripe), input flat bit j is placed at output byte (j mod LANES), bit (j div LANES). Destriping the result of a stripe therefore returns the original bytes for any pattern.
- R3: The direction is sampled with each accepted beat. Back-to-back beats may use different directions.
- R4: A beat accepted on a clock edge appears on `out_data` with `out_valid` high right after that edge (one cycle of latency).
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds its value.
- R6: After reset, `out_valid` is low and `in_ready` is high.
- R7: With `out_ready` held high, a new beat is accepted on every cycle.
- R8: Every accepted beat keeps its count of one bits.
- R9: With LANES=1, data passes through unchanged in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | 0 = stripe, 1 = destripe; sampled with the beat |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 8*LANES | Input byte group |
| out_valid | output | 1 | Output register holds a beat |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 8*LANES | Transposed byte group |

## Verification
The bound checker watches the handshake on every cycle. It checks that a held beat stalls the input and stays stable, that an accepted beat shows up after exactly one edge, that an empty register never refuses input, and that bit counts survive each transpose. The exact bit positions of the stripe and destripe mappings, the per-beat direction switching, the round trip of arbitrary patterns, and the single-lane pass-through can only be shown by the bench's scenarios with known patterns.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

    // Output register occupancy.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } xpose_state_e;

    // Flat position in the lane-major vector of logical stream bit j.
    function automatic int lane_pos(input int j, input int lanes, input int byte_w);
        return (j % lanes) * byte_w + (j / lanes);
    endfunction

endpackage

// File: rtl/stripe_map.sv
module stripe_map #(
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    localparam int TOTAL = LANES * BYTE_W
) (
    input  logic             dir_i,
    input  logic [TOTAL-1:0] src_i,
    output logic [TOTAL-1:0] dst_o
);
    import stripe_pkg::*;

    logic [TOTAL-1:0] striped;
    logic [TOTAL-1:0] destriped;

    // Pure wiring: each bit has one source in each direction.
    for (genvar j = 0; j < TOTAL; j++) begin : g_bit
        localparam int P = lane_pos(j, LANES, BYTE_W);
        assign striped[j]   = src_i[P];
        assign destriped[P] = src_i[j];
    end

    assign dst_o = dir_i ? destriped : striped;

endmodule

// File: rtl/stripe_ctrl.sv
module stripe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load_en
);
    import stripe_pkg::*;

    xpose_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_en   = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                load_en  = in_valid;
                if (in_valid) state_d = ST_FULL;                  // LOAD
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                load_en   = in_valid && out_ready;
                if (out_ready && !in_valid) state_d = ST_EMPTY;   // DRAIN
                // STREAM and STALL both stay in ST_FULL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

endmodule

// File: rtl/bit_stripe_xpose.sv
module bit_stripe_xpose #(
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    localparam int TOTAL = LANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_i,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TOTAL-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [TOTAL-1:0] out_data
);
    logic             load_en;
    logic [TOTAL-1:0] mapped;

    stripe_map #(.LANES(LANES), .BYTE_W(BYTE_W)) u_map (
        .dir_i (dir_i),
        .src_i (in_data),
        .dst_o (mapped)
    );

    stripe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_en   (load_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       out_data <= '0;
        else if (load_en) out_data <= mapped;
    end

endmodule

// File: rtl/bit_stripe_xpose_chk.sv
module bit_stripe_xpose_chk #(
    parameter int TOTAL = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [TOTAL-1:0] in_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [TOTAL-1:0] out_data
);
    // R5: a refused output blocks the input
    p_stall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R5: a refused output is held unchanged
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4: an accepted beat is visible after one edge
    p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R7: an empty register never refuses input
    p_empty_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R8: the one-bit count survives the transpose
    p_popcount_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ($countones(out_data) == $countones($past(in_data))));

endmodule

bind bit_stripe_xpose bit_stripe_xpose_chk #(.TOTAL(TOTAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_bit_stripe_xpose.sv
module test_bit_stripe_xpose;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        dir_i = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
    logic        in_ready, out_valid;
    logic [15:0] in_data = '0, out_data;

    logic        n1_dir = 1'b0, n1_valid = 1'b0;
    logic        n1_in_ready, n1_out_valid;
    logic [7:0]  n1_in = '0, n1_out;

    bit_stripe_xpose #(.LANES(2)) i_bit_stripe_xpose (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data));

    bit_stripe_xpose #(.LANES(1)) i_bit_stripe_xpose_n1 (
        .clk(clk), .rst_n(rst_n), .dir_i(n1_dir), .in_valid(n1_valid),
        .in_ready(n1_in_ready), .in_data(n1_in), .out_valid(n1_out_valid),
        .out_ready(1'b1), .out_data(n1_out));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {dir, input, expected} for LANES=2, hand-derived from R1/R2
    localparam int NV = 13;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 16'h00FF, 16'h5555},
        {1'b0, 16'hFF00, 16'hAAAA},
        {1'b0, 16'hFFFF, 16'hFFFF},
        {1'b0, 16'h0001, 16'h0001},
        {1'b0, 16'h0100, 16'h0002},
        {1'b0, 16'h0080, 16'h4000},
        {1'b0, 16'h8000, 16'h8000},
        {1'b0, 16'h0010, 16'h0100},
        {1'b0, 16'h00F0, 16'h5500},
        {1'b0, 16'h0F00, 16'h00AA},
        {1'b1, 16'h0002, 16'h0100},
        {1'b1, 16'h4000, 16'h0080},
        {1'b1, 16'h5500, 16'h00F0}
    };

    // One beat with out_ready high; result sampled one edge later.
    task automatic beat(input logic d, input logic [15:0] x, output logic [15:0] y);
        dir_i = d; in_data = x; in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk("R4 valid", {15'd0, out_valid}, 16'd1);
        y = out_data;
    endtask

    initial begin
        logic [15:0] r, back;
        @(negedge clk);
        chk("R6 out_valid", {15'd0, out_valid}, 16'd0);
        chk("R6 in_ready", {15'd0, in_ready}, 16'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            beat(VEC[k][32], VEC[k][31:16], r);
            chk(VEC[k][32] ? "R2 destripe map" : "R1 stripe map", r, VEC[k][15:0]);
        end

        // R2: single-bit, all-ones and random round trips
        for (int b = 0; b < 16; b++) begin
            beat(1'b0, 16'(1) << b, r);
            beat(1'b1, r, back);
            chk("R2 single-bit round trip", back, 16'(1) << b);
        end
        for (int k = 0; k < 40; k++) begin
            logic [15:0] x;
            x = 16'($urandom);
            beat(1'b0, x, r);
            beat(1'b1, r, back);
            chk("R2 random round trip", back, x);
        end

        // R3 + R7: back-to-back beats with alternating direction
        dir_i = 1'b0; in_data = 16'h0080; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        chk("R7 ready while streaming", {15'd0, in_ready}, 16'd1);
        @(posedge clk); @(negedge clk);
        chk("R3 first beat stripe", out_data, 16'h4000);
        chk("R7 ready while streaming", {15'd0, in_ready}, 16'd1);
        dir_i = 1'b1; in_data = 16'h4000;
        @(posedge clk); @(negedge clk);
        chk("R3 second beat destripe", out_data, 16'h0080);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R4 drained", {15'd0, out_valid}, 16'd0);

        // R5: backpressure
        out_ready = 1'b0; dir_i = 1'b0; in_data = 16'h0001; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 holds A", out_data, 16'h0001);
        chk("R5 in_ready low", {15'd0, in_ready}, 16'd0);
        in_data = 16'h0100;
        @(posedge clk); @(negedge clk);
        chk("R5 A still held", out_data, 16'h0001);
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 B after release", out_data, 16'h0002);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);

        // R9: single lane passes data through
        n1_dir = 1'b0; n1_in = 8'hA5; n1_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R9 stripe pass", {8'd0, n1_out}, 16'h00A5);
        n1_dir = 1'b1; n1_in = 8'h3C;
        @(posedge clk); @(negedge clk);
        chk("R9 destripe pass", {8'd0, n1_out}, 16'h003C);
        n1_valid = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule